// File: doc/BRIEF.md
# Isolation Group Freeze Filter

This block keeps a freeze state table with one entry per isolation group, 256 entries by default. Each entry holds two frozen flags and a small error-cause code. The first flag covers the outbound memory-mapped direction and the second covers the inbound DMA direction. A hardware freeze event sets both flags of an entry in the same cycle. Software can clear either flag on its own and can also raise a freeze of its own.

Tagged transactions pass through the block, one per cycle. Each carries a group number, a kind and a data word. Traffic from a group whose relevant flag is clear is forwarded unchanged one cycle later. Traffic that is blocked is squashed according to its kind. Blocked stores vanish. Blocked loads are not forwarded; the block answers them itself with an all-ones completion. Blocked MSIs vanish. The group number arrives already resolved; the block does not derive it and does not spread a freeze to other groups.

Top module: `iso_freeze_filter`

## Requirements
- R1: After reset every entry has both flags clear and cause 0, and `fwd_valid`, `cpl_valid` and `reg_rvalid` are low.
- R2: A freeze event (`frz_valid`) or a software freeze (`reg_op`=3) sets both flags of the addressed entry at the same clock edge. A software freeze records cause 0. When both request the same entry in the same cycle, the hardware cause is recorded.
- R3: `reg_op`=1 clears only the MMIO flag of `reg_grp`, and `reg_op`=2 clears only the DMA flag. The other flag is left unchanged.
- R4: If a freeze request and a software clear address the same entry in the same cycle, both flags end up set.
- R5: The cause field is written only by a freeze that finds both flags of its entry clear. A freeze on an entry with either flag still set leaves the cause unchanged. The cause stays readable after the flags are cleared.
- R6: A store whose gating flag is set produces neither a forward nor a completion. This covers `txn_kind`=1 (MMIO store, gated by MMIO) and `txn_kind`=3 (DMA write, gated by DMA).
- R7: A load whose gating flag is set is not forwarded. Instead, one cycle later, `cpl_valid` rises with `cpl_data` all ones and `cpl_grp` equal to the group. This covers `txn_kind`=0 (MMIO read, gated by MMIO) and `txn_kind`=2 (DMA read, gated by DMA).
- R8: An MSI (`txn_kind`=4) from a group whose DMA flag is set produces neither a forward nor a completion.
- R9: A transaction whose gating flag is clear appears one cycle later on `fwd_valid`, `fwd_kind`, `fwd_grp` and `fwd_data`, unchanged. The MMIO flag gates only kinds 0 and 1. The DMA flag gates only kinds 2, 3 and 4.
- R10: A read (`reg_op`=0) returns `{cause, dma, mmio}` on `reg_rdata` one cycle later, with `reg_rvalid` high. Both reads and transaction filtering use the table state as it was before any update made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frz_valid | input | 1 | Hardware freeze request |
| frz_grp | input | GRP_W | Group to freeze |
| frz_cause | input | CAUSE_W | Error cause for the freeze |
| reg_valid | input | 1 | Register access strobe |
| reg_op | input | 2 | 0 read, 1 clear MMIO, 2 clear DMA, 3 software freeze |
| reg_grp | input | GRP_W | Group addressed by the access |
| reg_rvalid | output | 1 | Read data valid |
| reg_rdata | output | CAUSE_W+2 | bit0 MMIO flag, bit1 DMA flag, upper bits cause |
| txn_valid | input | 1 | Transaction valid |
| txn_kind | input | 3 | 0 MMIO read, 1 MMIO write, 2 DMA read, 3 DMA write, 4 MSI |
| txn_grp | input | GRP_W | Group of the transaction |
| txn_data | input | DATA_W | Transaction data |
| fwd_valid | output | 1 | Forwarded transaction valid |
| fwd_kind | output | 3 | Forwarded kind |
| fwd_grp | output | GRP_W | Forwarded group |
| fwd_data | output | DATA_W | Forwarded data |
| cpl_valid | output | 1 | Local all-ones completion for a blocked load |
| cpl_grp | output | GRP_W | Group of the completion |
| cpl_data | output | DATA_W | Completion data |

## Verification
The bench builds groups in each of four flag states: none set, both set, only DMA set and only MMIO set. It then sends every transaction kind at each of them. A design that paired the wrong flag with a kind would forward or squash exactly the wrong cells of that grid. A clear that raced a freeze is checked, since a design that let the clear win would leave an entry half open while hardware still considers it faulty. The bench also re-freezes a partly cleared entry and looks for the original cause. A design that latched on every freeze would overwrite that cause. Same-cycle freeze with a transaction or a read shows whether the design applied the new state one cycle early.

// File: rtl/iso_freeze_filter.sv
module iso_freeze_filter #(
  parameter int NUM_GRP = 256,
  parameter int DATA_W  = 32,
  parameter int CAUSE_W = 4,
  localparam int GRP_W  = $clog2(NUM_GRP)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frz_valid,
  input  logic [GRP_W-1:0]     frz_grp,
  input  logic [CAUSE_W-1:0]   frz_cause,
  input  logic                 reg_valid,
  input  logic [1:0]           reg_op,
  input  logic [GRP_W-1:0]     reg_grp,
  output logic                 reg_rvalid,
  output logic [CAUSE_W+1:0]   reg_rdata,
  input  logic                 txn_valid,
  input  logic [2:0]           txn_kind,
  input  logic [GRP_W-1:0]     txn_grp,
  input  logic [DATA_W-1:0]    txn_data,
  output logic                 fwd_valid,
  output logic [2:0]           fwd_kind,
  output logic [GRP_W-1:0]     fwd_grp,
  output logic [DATA_W-1:0]    fwd_data,
  output logic                 cpl_valid,
  output logic [GRP_W-1:0]     cpl_grp,
  output logic [DATA_W-1:0]    cpl_data
);
  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] OP_CLR_M = 2'd1;
  localparam logic [1:0] OP_CLR_D = 2'd2;
  localparam logic [1:0] OP_SET   = 2'd3;

  localparam logic [2:0] K_MRD = 3'd0;
  localparam logic [2:0] K_MWR = 3'd1;
  localparam logic [2:0] K_DRD = 3'd2;
  localparam logic [2:0] K_DWR = 3'd3;
  localparam logic [2:0] K_MSI = 3'd4;

  logic [NUM_GRP-1:0]              mmio_q, dma_q;
  logic [NUM_GRP-1:0][CAUSE_W-1:0] cause_q;
  logic [NUM_GRP-1:0]              hw_hit, frz_hit, clr_m_hit, clr_d_hit;

  wire sw_set = reg_valid && reg_op == OP_SET;
  wire sw_clm = reg_valid && reg_op == OP_CLR_M;
  wire sw_cld = reg_valid && reg_op == OP_CLR_D;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_dec
    assign hw_hit[g]    = frz_valid && frz_grp == GRP_W'(g);
    assign frz_hit[g]   = hw_hit[g] || (sw_set && reg_grp == GRP_W'(g));
    assign clr_m_hit[g] = sw_clm && reg_grp == GRP_W'(g);
    assign clr_d_hit[g] = sw_cld && reg_grp == GRP_W'(g);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mmio_q  <= '0;
      dma_q   <= '0;
      cause_q <= '0;
    end else begin
      for (int i = 0; i < NUM_GRP; i++) begin
        if (frz_hit[i]) begin
          mmio_q[i] <= 1'b1;
          dma_q[i]  <= 1'b1;
          if (!(mmio_q[i] || dma_q[i]))
            cause_q[i] <= hw_hit[i] ? frz_cause : '0;
        end else begin
          if (clr_m_hit[i]) mmio_q[i] <= 1'b0;
          if (clr_d_hit[i]) dma_q[i]  <= 1'b0;
        end
      end
    end
  end

  logic blocked, is_load;
  always_comb begin
    unique case (txn_kind)
      K_MRD, K_MWR:        blocked = mmio_q[txn_grp];
      K_DRD, K_DWR, K_MSI: blocked = dma_q[txn_grp];
      default:             blocked = 1'b0;
    endcase
  end
  assign is_load = txn_kind == K_MRD || txn_kind == K_DRD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_valid  <= 1'b0;
      fwd_kind   <= '0;
      fwd_grp    <= '0;
      fwd_data   <= '0;
      cpl_valid  <= 1'b0;
      cpl_grp    <= '0;
      cpl_data   <= '0;
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      fwd_valid <= txn_valid && !blocked;
      cpl_valid <= txn_valid && blocked && is_load;
      if (txn_valid && !blocked) begin
        fwd_kind <= txn_kind;
        fwd_grp  <= txn_grp;
        fwd_data <= txn_data;
      end
      if (txn_valid && blocked && is_load) begin
        cpl_grp  <= txn_grp;
        cpl_data <= '1;
      end
      reg_rvalid <= reg_valid && reg_op == OP_READ;
      if (reg_valid && reg_op == OP_READ)
        reg_rdata <= {cause_q[reg_grp], dma_q[reg_grp], mmio_q[reg_grp]};
    end
  end
endmodule

// File: rtl/iso_freeze_filter_chk.sv
module iso_freeze_filter_chk #(
  parameter int NUM_GRP = 256,
  parameter int DATA_W  = 32,
  parameter int CAUSE_W = 4,
  localparam int GRP_W  = $clog2(NUM_GRP)
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              frz_valid,
  input logic [GRP_W-1:0]                  frz_grp,
  input logic                              reg_valid,
  input logic [1:0]                        reg_op,
  input logic [GRP_W-1:0]                  reg_grp,
  input logic                              txn_valid,
  input logic [2:0]                        txn_kind,
  input logic [GRP_W-1:0]                  txn_grp,
  input logic [DATA_W-1:0]                 txn_data,
  input logic                              fwd_valid,
  input logic [DATA_W-1:0]                 fwd_data,
  input logic                              cpl_valid,
  input logic [DATA_W-1:0]                 cpl_data,
  input logic [NUM_GRP-1:0]                mmio_q,
  input logic [NUM_GRP-1:0]                dma_q,
  input logic [NUM_GRP-1:0][CAUSE_W-1:0]   cause_q
);
  assert_freeze_sets_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frz_valid |=> mmio_q[$past(frz_grp)] && dma_q[$past(frz_grp)]);

  assert_clear_mmio_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && reg_op == 2'd1 && !(frz_valid && frz_grp == reg_grp)
    |=> !mmio_q[$past(reg_grp)] && dma_q[$past(reg_grp)] == $past(dma_q[reg_grp]));

  assert_freeze_beats_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frz_valid && reg_valid && (reg_op == 2'd1 || reg_op == 2'd2) && reg_grp == frz_grp
    |=> mmio_q[$past(frz_grp)] && dma_q[$past(frz_grp)]);

  assert_cause_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frz_valid && (mmio_q[frz_grp] || dma_q[frz_grp])
    |=> cause_q[$past(frz_grp)] == $past(cause_q[frz_grp]));

  assert_store_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && txn_kind == 3'd1 && mmio_q[txn_grp] |=> !fwd_valid && !cpl_valid);

  assert_load_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && txn_kind == 3'd0 && mmio_q[txn_grp]
    |=> cpl_valid && cpl_data == '1 && !fwd_valid);

  assert_msi_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && txn_kind == 3'd4 && dma_q[txn_grp] |=> !fwd_valid && !cpl_valid);

  assert_pass_through_R9: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && txn_kind == 3'd0 && !mmio_q[txn_grp]
    |=> fwd_valid && !cpl_valid && fwd_data == $past(txn_data));
endmodule

bind iso_freeze_filter iso_freeze_filter_chk #(
  .NUM_GRP(NUM_GRP), .DATA_W(DATA_W), .CAUSE_W(CAUSE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frz_valid(frz_valid), .frz_grp(frz_grp),
  .reg_valid(reg_valid), .reg_op(reg_op), .reg_grp(reg_grp),
  .txn_valid(txn_valid), .txn_kind(txn_kind), .txn_grp(txn_grp), .txn_data(txn_data),
  .fwd_valid(fwd_valid), .fwd_data(fwd_data), .cpl_valid(cpl_valid), .cpl_data(cpl_data),
  .mmio_q(mmio_q), .dma_q(dma_q), .cause_q(cause_q)
);

// File: tb/tb_iso_freeze_filter.sv
`timescale 1ns/1ps
module tb_iso_freeze_filter;
  localparam int NUM_GRP = 256;
  localparam int DATA_W  = 32;
  localparam int CAUSE_W = 4;
  localparam int GRP_W   = $clog2(NUM_GRP);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frz_valid = 1'b0;
  logic [GRP_W-1:0] frz_grp = '0;
  logic [CAUSE_W-1:0] frz_cause = '0;
  logic reg_valid = 1'b0;
  logic [1:0] reg_op = '0;
  logic [GRP_W-1:0] reg_grp = '0;
  logic reg_rvalid;
  logic [CAUSE_W+1:0] reg_rdata;
  logic txn_valid = 1'b0;
  logic [2:0] txn_kind = '0;
  logic [GRP_W-1:0] txn_grp = '0;
  logic [DATA_W-1:0] txn_data = '0;
  logic fwd_valid, cpl_valid;
  logic [2:0] fwd_kind;
  logic [GRP_W-1:0] fwd_grp, cpl_grp;
  logic [DATA_W-1:0] fwd_data, cpl_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  iso_freeze_filter #(.NUM_GRP(NUM_GRP), .DATA_W(DATA_W), .CAUSE_W(CAUSE_W)) dut (
    .clk(clk), .rst_n(rst_n), .frz_valid(frz_valid), .frz_grp(frz_grp), .frz_cause(frz_cause),
    .reg_valid(reg_valid), .reg_op(reg_op), .reg_grp(reg_grp),
    .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
    .txn_valid(txn_valid), .txn_kind(txn_kind), .txn_grp(txn_grp), .txn_data(txn_data),
    .fwd_valid(fwd_valid), .fwd_kind(fwd_kind), .fwd_grp(fwd_grp), .fwd_data(fwd_data),
    .cpl_valid(cpl_valid), .cpl_grp(cpl_grp), .cpl_data(cpl_data));

  // {kind[2:0], grp[7:0], expect_fwd, expect_cpl}
  localparam int NVEC = 20;
  localparam logic [12:0] VEC [NVEC] = '{
    {3'd0, 8'd0, 2'b10}, {3'd1, 8'd0, 2'b10}, {3'd2, 8'd0, 2'b10}, {3'd3, 8'd0, 2'b10}, {3'd4, 8'd0, 2'b10},
    {3'd0, 8'd5, 2'b01}, {3'd1, 8'd5, 2'b00}, {3'd2, 8'd5, 2'b01}, {3'd3, 8'd5, 2'b00}, {3'd4, 8'd5, 2'b00},
    {3'd0, 8'd9, 2'b10}, {3'd1, 8'd9, 2'b10}, {3'd2, 8'd9, 2'b01}, {3'd3, 8'd9, 2'b00}, {3'd4, 8'd9, 2'b00},
    {3'd0, 8'd12, 2'b01}, {3'd1, 8'd12, 2'b00}, {3'd2, 8'd12, 2'b10}, {3'd3, 8'd12, 2'b10}, {3'd4, 8'd12, 2'b10}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic freeze(input int grp, input int cause);
    @(negedge clk);
    frz_valid = 1'b1; frz_grp = GRP_W'(grp); frz_cause = CAUSE_W'(cause);
    @(negedge clk);
    frz_valid = 1'b0;
  endtask

  task automatic regop(input int op, input int grp);
    @(negedge clk);
    reg_valid = 1'b1; reg_op = 2'(op); reg_grp = GRP_W'(grp);
    @(negedge clk);
    reg_valid = 1'b0;
  endtask

  task automatic read_chk(input string req, input int grp, input logic [CAUSE_W+1:0] exp);
    regop(0, grp);
    check(req, {63'd0, reg_rvalid}, 64'd1);
    check(req, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic txn(input int kind, input int grp, input logic [DATA_W-1:0] data);
    @(negedge clk);
    txn_valid = 1'b1; txn_kind = 3'(kind); txn_grp = GRP_W'(grp); txn_data = data;
    @(negedge clk);
    txn_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1 fwd_valid", {63'd0, fwd_valid}, 64'd0);
    check("R1 cpl_valid", {63'd0, cpl_valid}, 64'd0);
    check("R1 reg_rvalid", {63'd0, reg_rvalid}, 64'd0);
    read_chk("R1 entry 0", 0, '0);
    read_chk("R1 entry 255", 255, '0);

    // Build flag states: 5 both, 9 DMA only, 12 MMIO only
    freeze(5, 3);
    freeze(9, 1);
    regop(1, 9);
    freeze(12, 2);
    regop(2, 12);
    read_chk("R2 both flags set", 5, {4'd3, 2'b11});
    read_chk("R3 MMIO cleared, DMA kept", 9, {4'd1, 2'b10});
    read_chk("R3 DMA cleared, MMIO kept", 12, {4'd2, 2'b01});

    // R6 R7 R8 R9 vector walk
    for (int v = 0; v < NVEC; v++) begin
      logic [DATA_W-1:0] d;
      d = 32'hA5000000 | 32'(v);
      txn(int'(VEC[v][12:10]), int'(VEC[v][9:2]), d);
      check($sformatf("R9 R6 R8 vec %0d fwd_valid", v), {63'd0, fwd_valid}, {63'd0, VEC[v][1]});
      check($sformatf("R7 vec %0d cpl_valid", v), {63'd0, cpl_valid}, {63'd0, VEC[v][0]});
      if (VEC[v][1]) begin
        check($sformatf("R9 vec %0d data", v), 64'(fwd_data), 64'(d));
        check($sformatf("R9 vec %0d kind", v), 64'(fwd_kind), 64'(VEC[v][12:10]));
        check($sformatf("R9 vec %0d grp", v), 64'(fwd_grp), 64'(VEC[v][9:2]));
      end
      if (VEC[v][0]) begin
        check($sformatf("R7 vec %0d ones", v), 64'(cpl_data), 64'(32'hFFFFFFFF));
        check($sformatf("R7 vec %0d grp", v), 64'(cpl_grp), 64'(VEC[v][9:2]));
      end
    end

    // R4: freeze and clear on the same entry in the same cycle
    @(negedge clk);
    frz_valid = 1'b1; frz_grp = 8'd50; frz_cause = 4'd7;
    reg_valid = 1'b1; reg_op = 2'd1; reg_grp = 8'd50;
    @(negedge clk);
    frz_valid = 1'b0; reg_valid = 1'b0;
    read_chk("R4 freeze wins over clear", 50, {4'd7, 2'b11});

    // R5: first-freeze cause latching
    freeze(30, 6);
    freeze(30, 2);
    read_chk("R5 refreeze keeps cause", 30, {4'd6, 2'b11});
    regop(1, 30);
    freeze(30, 9);
    read_chk("R5 partial frozen keeps cause", 30, {4'd6, 2'b11});
    regop(1, 30);
    regop(2, 30);
    read_chk("R5 cause sticky after clear", 30, {4'd6, 2'b00});
    freeze(30, 9);
    read_chk("R5 new first freeze latches", 30, {4'd9, 2'b11});

    // R2: software freeze records cause 0; same-cycle hw and sw uses hw cause
    regop(3, 40);
    read_chk("R2 software freeze", 40, {4'd0, 2'b11});
    @(negedge clk);
    frz_valid = 1'b1; frz_grp = 8'd41; frz_cause = 4'd5;
    reg_valid = 1'b1; reg_op = 2'd3; reg_grp = 8'd41;
    @(negedge clk);
    frz_valid = 1'b0; reg_valid = 1'b0;
    read_chk("R2 hw cause over sw", 41, {4'd5, 2'b11});

    // R10: same-cycle freeze vs transaction and vs read
    @(negedge clk);
    frz_valid = 1'b1; frz_grp = 8'd20; frz_cause = 4'd4;
    txn_valid = 1'b1; txn_kind = 3'd0; txn_grp = 8'd20; txn_data = 32'h12345678;
    reg_valid = 1'b1; reg_op = 2'd0; reg_grp = 8'd20;
    @(negedge clk);
    frz_valid = 1'b0; txn_valid = 1'b0; reg_valid = 1'b0;
    check("R10 txn sees old state", {63'd0, fwd_valid}, 64'd1);
    check("R10 txn data", 64'(fwd_data), 64'h12345678);
    check("R10 read sees old state", 64'(reg_rdata), 64'd0);
    txn(0, 20, 32'h1);
    check("R10 next txn blocked", {63'd0, cpl_valid}, 64'd1);
    check("R10 next txn not forwarded", {63'd0, fwd_valid}, 64'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule